// File: doc/BRIEF.md
# Self-Clocked Serial Result Port for a Delta-Sigma Converter

This block is the digital output side of a delta-sigma converter that makes its own serial clock. It moves through three states: converting, sleeping with a finished result, and shifting that result out. A single active-low select input controls it. The block drives a data line with an output enable (tri-state) and a serial clock that it generates from the system clock. The system clock stands in for the converter's oscillator. The filter supplies a completion strobe and a 32-bit word.

While select is low and no transfer is running, the data line shows the conversion status: 1 while converting and 0 while asleep. Once select has been held low in sleep for a fixed test window, the block raises its clock and shifts out a 32-bit frame, starting with the status bit. Raising select during the transfer aborts it. Both an abort and a completed frame start a fresh conversion at once.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the block is converting. With `cs_n` high, `sdo_oe` is 0 and `sck` is 1. With `cs_n` low, `sdo` is 1.
- R2: `sdo_oe` is 1 exactly when `cs_n` is low. `sdo` is high-impedance (enable 0) whenever `cs_n` is high.
- R3: Outside a transfer with `cs_n` low, `sdo` carries the status bit: 1 while converting, 0 while asleep.
- R4: A conversion ends on the first `conv_done` pulse sampled at least `CONV_CYCLES` cycles after the conversion began. That edge captures `result` and the block enters sleep. Earlier pulses have no effect.
- R5: In sleep with `cs_n` high the block stays asleep indefinitely and keeps the captured word for the next transfer.
- R6: The transfer starts after `TEST_CYCLES` consecutive sleep cycles with `cs_n` low. Any high cycle restarts the count. This holds whether `cs_n` fell during sleep or was already low when the conversion ended.
- R7: While `cs_n` is low and no transfer is running, `sck` is 0 unless R11 applies. While `cs_n` is high outside a transfer, `sck` is 1.
- R8: A frame has 32 rising `sck` edges. High and low phases each last `SCK_HALF` cycles, and the first rising edge coincides with the transfer start. On rising edge k (1..32) `sdo` holds frame bit 32-k. Frame bit 31 is the status bit (0). `result[31]` is ignored and frame bits 30..0 equal `result[30:0]`. `sdo` changes only as `sck` falls.
- R9: A complete frame ends after the high phase of the 32nd rising edge. The block then starts a new conversion, `sdo` reads 1, and the new conversion again ignores `conv_done` for `CONV_CYCLES` cycles.
- R10: `cs_n` high during a transfer aborts it and starts a new conversion on the next cycle, subject to the R4 rule.
- R11: After a complete frame, `sck` stays 1 until `cs_n` goes high or the next conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, stands in for the oscillator |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| conv_done | input | 1 | Completion strobe from the filter |
| result | input | FRAME_W | Conversion word from the filter |
| sck | output | 1 | Generated serial clock |
| sdo | output | 1 | Serial data / status value |
| sdo_oe | output | 1 | Output enable for the data line |

## Verification
The bench builds the block with `CONV_CYCLES`=40, `TEST_CYCLES`=5 and `SCK_HALF`=2. This puts conversion ends, long sleeps with select high, a restarted test window, an abort in mid-frame and three full frames within a few hundred cycles. With a half period of 2, every clock level spans more than one system cycle, so a change of `sdo` in the middle of a phase would be visible. A short conversion length lets early strobes be aimed just before the threshold, right after reset, after a completed frame and after an abort.

// File: rtl/adc_sp_pkg.sv
// Shared types for the serial result port.
// Assumes nothing beyond IEEE 1800-2017.
package adc_sp_pkg;

    // Top-level sequencing states
    typedef enum logic [1:0] {
        SP_CONV  = 2'd0,
        SP_SLEEP = 2'd1,
        SP_OUT   = 2'd2
    } sp_state_e;

endpackage

// File: rtl/adc_sp_conv_timer.sv
// Conversion timer: counts cycles spent converting and accepts a completion
// strobe only once CONV_CYCLES have elapsed.
// Assumes run is high exactly while the top is in the converting state.
module adc_sp_conv_timer #(
    parameter int CONV_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic conv_done,
    output logic conv_end
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic [CW-1:0] age;

    // Age counter: cleared outside conversion, saturates at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (!run) begin
            age <= '0;
        end else if (age != CW'(CONV_CYCLES)) begin
            age <= age + 1'b1;
        end
    end

    assign conv_end = run && conv_done && (age == CW'(CONV_CYCLES));
endmodule

// File: rtl/adc_sp_test_window.sv
// Test window: counts consecutive sleep cycles with select low and flags the
// cycle on which the transfer must begin.
// Assumes armed is high exactly while the top is asleep.
module adc_sp_test_window #(
    parameter int TEST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic cs_n,
    output logic window_done
);
    localparam int WW = $clog2(TEST_CYCLES + 1);

    logic [WW-1:0] low_cnt;

    // Low-time counter: restarts on any high cycle or outside sleep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!armed || cs_n) begin
            low_cnt <= '0;
        end else if (!window_done) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign window_done = armed && !cs_n && (low_cnt == WW'(TEST_CYCLES - 1));
endmodule

// File: rtl/adc_sp_serializer.sv
// Serializer: holds the frame word, generates the serial clock phases and
// shifts one bit on every falling clock edge.
// Assumes start is a single-cycle pulse and that run is high only during a
// transfer with select low.
module adc_sp_serializer #(
    parameter int FRAME_W  = 32,
    parameter int SCK_HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] word,
    input  logic               start,
    input  logic               run,
    output logic               ser_sck,
    output logic               ser_bit,
    output logic               frame_end
);
    localparam int PW = $clog2(SCK_HALF + 1);
    localparam int EW = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] shreg;
    logic [PW-1:0]      ph;
    logic [EW-1:0]      rises;
    logic               sck_q;
    logic               phase_last;
    logic               falling;

    assign phase_last = (ph == PW'(SCK_HALF - 1));
    assign frame_end  = run && sck_q && phase_last && (rises == EW'(FRAME_W - 1));
    assign falling    = run && sck_q && phase_last && !frame_end;

    // Frame register: status bit on top, shifted left on each falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= {1'b0, word[FRAME_W-2:0]};
        end else if (falling) begin
            shreg <= {shreg[FRAME_W-2:0], 1'b1};
        end
    end

    // Clock phase generator: SCK_HALF cycles per level, counts rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= '0;
            sck_q <= 1'b1;
            rises <= '0;
        end else if (start) begin
            ph    <= '0;
            sck_q <= 1'b1;
            rises <= '0;
        end else if (run) begin
            if (phase_last) begin
                ph <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rises <= rises + 1'b1;
                end else if (!frame_end) begin
                    sck_q <= 1'b0;
                end
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    assign ser_sck = sck_q;
    assign ser_bit = shreg[FRAME_W-1];
endmodule

// File: rtl/adc_serial_port.sv
// Serial result port top: sequences conversion, sleep and transfer, and
// builds the status, data and clock pins from the three sub-blocks.
// Assumes cs_n and conv_done are synchronous to clk.
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int FRAME_W     = 32,
    parameter int CONV_CYCLES = 20000,
    parameter int TEST_CYCLES = 4,
    parameter int SCK_HALF    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               conv_done,
    input  logic [FRAME_W-1:0] result,
    output logic               sck,
    output logic               sdo,
    output logic               sdo_oe
);
    sp_state_e state, state_nxt;
    logic      conv_end;
    logic      window_done;
    logic      frame_end;
    logic      ser_sck;
    logic      ser_bit;
    logic      park;
    logic      ser_run;

    assign ser_run = (state == SP_OUT) && !cs_n;

    adc_sp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state == SP_CONV),
        .conv_done (conv_done),
        .conv_end  (conv_end)
    );

    adc_sp_test_window #(.TEST_CYCLES(TEST_CYCLES)) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed       (state == SP_SLEEP),
        .cs_n        (cs_n),
        .window_done (window_done)
    );

    adc_sp_serializer #(.FRAME_W(FRAME_W), .SCK_HALF(SCK_HALF)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (conv_end),
        .word      (result),
        .start     (window_done),
        .run       (ser_run),
        .ser_sck   (ser_sck),
        .ser_bit   (ser_bit),
        .frame_end (frame_end)
    );

    // Next-state choice for the three-state sequence
    always_comb begin
        state_nxt = state;
        unique case (state)
            SP_CONV:  if (conv_end)    state_nxt = SP_SLEEP;
            SP_SLEEP: if (window_done) state_nxt = SP_OUT;
            SP_OUT:   if (cs_n || frame_end) state_nxt = SP_CONV;
            default:  state_nxt = SP_CONV;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SP_CONV;
        else        state <= state_nxt;
    end

    // Park flag: keeps the clock high after a complete frame
    always_ff @(posedge clk) begin
        if (!rst_n)                      park <= 1'b0;
        else if (cs_n || conv_end)       park <= 1'b0;
        else if (ser_run && frame_end)   park <= 1'b1;
    end

    assign sdo_oe = !cs_n;
    assign sdo    = (state == SP_OUT) ? ser_bit : (state == SP_CONV);
    assign sck    = (state == SP_OUT) ? ser_sck : (cs_n || park);
endmodule

// File: rtl/adc_serial_port_chk.sv
// Checker for the serial result port, attached to every instance by bind.
// Assumes it sees the top's state register and pins.
module adc_serial_port_chk
    import adc_sp_pkg::*;
#(
    parameter int FRAME_W = 32
) (
    input logic      clk,
    input logic      rst_n,
    input logic      cs_n,
    input sp_state_e st,
    input logic      sck,
    input logic      sdo
);
    localparam int EW = $clog2(FRAME_W + 2);

    logic          sck_d;
    logic [EW-1:0] rise_n;

    // Rising-edge count within the current transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d  <= 1'b1;
            rise_n <= '0;
        end else begin
            sck_d <= sck;
            if (st != SP_OUT)        rise_n <= '0;
            else if (sck && !sck_d)  rise_n <= rise_n + 1'b1;
        end
    end

    assert_sleep_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SP_SLEEP && cs_n) |=> (st == SP_SLEEP));

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SP_OUT && cs_n) |=> (st == SP_CONV));

    assert_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SP_OUT && $past(st) == SP_SLEEP) |-> ($past(!cs_n) && sck));

    assert_edge_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_n <= EW'(FRAME_W));

    assert_sdo_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SP_OUT && $past(st) == SP_OUT && !$fell(sck)) |-> $stable(sdo));

    assert_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == SP_OUT && st == SP_CONV && !cs_n && !$past(cs_n)) |-> (sck && sdo));
endmodule

bind adc_serial_port adc_serial_port_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .st    (state),
    .sck   (sck),
    .sdo   (sdo)
);

// File: tb/adc_serial_port_bench.sv
module adc_serial_port_bench;
    localparam int W  = 32;
    localparam int CV = 40;
    localparam int TW = 5;
    localparam int H  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic conv_done = 1'b0;
    logic [W-1:0] result = '0;
    logic sck, sdo, sdo_oe;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #10 clk = ~clk;

    adc_serial_port #(.FRAME_W(W), .CONV_CYCLES(CV), .TEST_CYCLES(TW), .SCK_HALF(H)) u_adc_serial_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .conv_done(conv_done),
        .result(result), .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // Behavioural reference: 0 converting, 1 asleep, 2 transferring
    int m_st, m_age, m_win, m_t;
    bit m_park;
    logic [W-1:0] m_word;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_age = 0; m_win = 0; m_t = 0; m_park = 0; m_word = '0;
        end else begin
            case (m_st)
                0: begin
                    if (cs_n) m_park = 0;
                    if (conv_done && m_age >= CV) begin
                        m_word = {1'b0, result[W-2:0]};
                        m_st = 1; m_win = 0; m_park = 0;
                    end else m_age++;
                end
                1: begin
                    if (cs_n) m_win = 0;
                    else if (m_win == TW - 1) begin m_st = 2; m_t = 0; end
                    else m_win++;
                end
                default: begin
                    if (cs_n) begin m_st = 0; m_age = 0; m_park = 0; end
                    else if (m_t == (2 * W - 1) * H - 1) begin m_st = 0; m_age = 0; m_park = 1; end
                    else m_t++;
                end
            endcase
        end
    end

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check("R2 sdo_oe", W'(sdo_oe), W'(!cs_n));
            if (m_st == 2) begin
                check("R8 sck", W'(sck), W'((m_t % (2 * H)) < H));
                if (!cs_n) check("R8 sdo", W'(sdo), W'(m_word[W - 1 - (m_t + H) / (2 * H)]));
            end else begin
                check("R7 R11 sck", W'(sck), W'(cs_n || (m_st == 0 && m_park)));
                if (!cs_n) check("R3 sdo", W'(sdo), W'(m_st == 0));
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    task automatic pulse(logic [W-1:0] w);
        conv_done = 1'b1; result = w;
        step();
        conv_done = 1'b0;
    endtask

    // From the first sleep cycle, count low-clock cycles until the transfer starts
    task automatic measure_window(string tag);
        int n = 0;
        look();
        while (!sck && n < 100) begin n++; look(); end
        check(tag, W'(n), W'(TW));
    endtask

    // Called at the negedge where sck has just risen for the first time
    task automatic capture(string tag, logic [W-1:0] exp);
        logic [W-1:0] w;
        int got = 1;
        int guard = 0;
        bit prev = 1;
        w = {{(W-1){1'b0}}, sdo};
        while (got < W && guard < 1000) begin
            look();
            guard++;
            if (sck && !prev) begin w = {w[W-2:0], sdo}; got++; end
            prev = sck;
        end
        check(tag, w, exp);
    endtask

    localparam logic [W-1:0] WA = 32'hA5C3_9E17;
    localparam logic [W-1:0] WB = 32'h5A3C_61E8;
    localparam logic [W-1:0] WC = 32'hF1E2_D3C4;
    localparam logic [W-1:0] WD = 32'h0F1E_2D3C;

    initial begin
        step(4);
        rst_n = 1'b1;
        cmp_on = 1;
        look();
        check("R1 sdo_oe", W'(sdo_oe), W'(0));
        check("R1 sck", W'(sck), W'(1));
        step(); cs_n = 1'b0;
        look();
        check("R1 sdo", W'(sdo), W'(1));
        check("R7 sck low", W'(sck), W'(0));
        step(8);
        pulse(32'hDEAD_BEEF);                 // R4: too early
        look();
        check("R4 early strobe", W'(sdo), W'(1));
        step(CV);
        pulse(WA);                            // R6: select already low
        measure_window("R6 window");
        capture("R8 frame A", {1'b0, WA[W-2:0]});
        look(); look(); look();
        check("R9 sdo", W'(sdo), W'(1));
        check("R11 sck parked", W'(sck), W'(1));
        step();
        pulse(32'h1234_5678);                 // R9: new conversion ignores it
        look();
        check("R9 early strobe", W'(sdo), W'(1));

        step(); cs_n = 1'b1;
        step(CV + 5);
        pulse(WB);
        step(100);                            // R5: long sleep with select high
        cs_n = 1'b0;
        look();
        check("R5 still asleep", W'(sdo), W'(0));
        step(2); cs_n = 1'b1;
        step(); cs_n = 1'b0;                  // R6: window restarts
        n_window_restart();
        capture("R5 R8 frame B", {1'b0, WB[W-2:0]});

        step(CV + 5);
        pulse(WC);
        measure_window("R6 window C");
        step(20);
        cs_n = 1'b1;                          // R10: abort
        step(); cs_n = 1'b0;
        look();
        check("R10 converting", W'(sdo), W'(1));
        step(5);
        pulse(32'hCAFE_0001);
        look();
        check("R10 early strobe", W'(sdo), W'(1));
        step(CV);
        pulse(WD);
        measure_window("R6 window D");
        capture("R8 frame D", {1'b0, WD[W-2:0]});
        step(4 * H);
        done = 1;
    end

    task automatic n_window_restart();
        int n = 0;
        look();
        while (!sck && n < 100) begin n++; look(); end
        check("R6 restarted window", W'(n), W'(TW));
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule